// File: doc/BRIEF.md
# Register Rename Map with Branch Checkpoints

This block renames one decoded instruction per cycle. Each instruction names two source registers and optionally one destination register out of 32 architectural registers. The block translates these into tags for 64 physical registers. A map table holds the current translation. A free vector tracks the physical registers that are not in use, and a busy vector records which physical registers are still waiting for a result. Every destination takes a fresh physical register. The register it replaces is reported so that it can be given back later, when the instruction graduates.

When a branch is renamed, the block saves a snapshot of the whole map table and the branch's alternate fetch address into one of four checkpoint slots. If the branch turns out to be mispredicted, the map table returns to that snapshot in a single cycle. The alternate address is presented for redirection. The physical registers handed out since the snapshot go back to the free vector. A branch that resolves correctly releases the oldest slot. Rename stalls when a destination is needed but no physical register is free, or when a branch needs a slot and all four are taken.

Top module: `rename_ckpt`

## Requirements
- R1: After reset, architectural register i maps to physical tag i. Physical tags 32 to 63 are free, and every busy flag reads 0.
- R2: Source tags and the old destination tag (`phys_old`) are read from the map as it stands before the current instruction's own destination update.
- R3: An accepted instruction with `has_dst`=1 receives the lowest-numbered free physical tag on `phys_d`, and the map entry for `dst` becomes that tag from the next cycle. An instruction with `has_dst`=0 allocates nothing.
- R4: A newly allocated tag is marked busy, so a later source read of it shows busy=1 until it is written back.
- R5: A writeback (`wb_valid`, `wb_tag`) clears that tag's busy bit. A source read of the same tag in the same cycle already shows busy=0.
- R6: A graduation (`grad_valid`, `grad_tag`) returns the tag to the free vector, and the tag is eligible for allocation from the next cycle.
- R7: When no tag is free and `has_dst`=1, `stall`=1 and `ren_ok`=0, and the map, the free vector and the busy vector keep their values.
- R8: An accepted branch (`is_branch`=1) stores the map as it stands after its own destination update, together with `br_alt`, in the slot reported on `ckpt_idx`. Slots are used in circular order starting at 0. With four slots live, a further branch stalls.
- R9: With `mispredict`=1, the map becomes the snapshot in slot `mis_idx` at the next edge. `redirect_addr` shows that slot's saved address in the same cycle, and every tag allocated since that snapshot is free again.
- R10: A mispredict releases its own slot and every younger slot. No instruction is renamed in a mispredict cycle, and the mispredict takes priority over `br_ok`.
- R11: `br_ok` releases the oldest live slot. The count of live slots used for the full check is the count at the start of the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An instruction is presented for rename |
| src_a | input | 5 | First source architectural register |
| src_b | input | 5 | Second source architectural register |
| dst | input | 5 | Destination architectural register |
| has_dst | input | 1 | Instruction writes a destination |
| is_branch | input | 1 | Instruction is a branch and takes a checkpoint |
| br_alt | input | 32 | Alternate fetch address saved with the checkpoint |
| mispredict | input | 1 | Restore from a checkpoint this cycle |
| mis_idx | input | 2 | Checkpoint slot to restore |
| br_ok | input | 1 | Oldest branch resolved correctly; release its slot |
| wb_valid | input | 1 | A result is written back |
| wb_tag | input | 6 | Physical tag written back |
| grad_valid | input | 1 | A physical tag is returned at graduation |
| grad_tag | input | 6 | Physical tag returned |
| ren_ok | output | 1 | Instruction accepted this cycle |
| stall | output | 1 | Instruction held for lack of a free tag or slot |
| phys_a | output | 6 | Physical tag of src_a |
| phys_b | output | 6 | Physical tag of src_b |
| phys_d | output | 6 | Physical tag allocated to dst |
| phys_old | output | 6 | Previous physical tag of dst |
| busy_a | output | 1 | phys_a has no valid value yet |
| busy_b | output | 1 | phys_b has no valid value yet |
| ckpt_idx | output | 2 | Slot taken by an accepted branch |
| redirect_addr | output | 32 | Saved alternate address of slot mis_idx |

## Verification
A corrupt map entry shows up as a wrong `phys_a`, `phys_b` or `phys_old` the first time that architectural register is read again. A free vector that leaks or duplicates a tag shows up on the next allocation, as an out-of-order `phys_d`, or as a `stall` that comes too early or too late while the 32 spare tags are drained. Checkpoint faults appear one cycle after a mispredict, when the restored map is read back and the tags freed by the restore are allocated again. They also appear as a wrong stall on the fifth live branch.

// File: rtl/rn_pkg.sv
package rn_pkg;
    parameter int LREGS  = 32;
    parameter int PREGS  = 64;
    parameter int NCKPT  = 4;
    parameter int ADDR_W = 32;

    localparam int LW = $clog2(LREGS);
    localparam int PW = $clog2(PREGS);
    localparam int CW = $clog2(NCKPT);

    typedef logic [LW-1:0]     lreg_t;
    typedef logic [PW-1:0]     preg_t;
    typedef logic [CW-1:0]     ckidx_t;
    typedef logic [CW:0]       ckcnt_t;
    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [PREGS-1:0]  pvec_t;
    typedef preg_t [LREGS-1:0] map_t;

    typedef struct packed {
        map_t  map;
        pvec_t since;
        addr_t alt;
    } ckpt_t;

    function automatic preg_t first_free(pvec_t v);
        preg_t r = '0;
        for (int i = PREGS - 1; i >= 0; i--)
            if (v[i]) r = preg_t'(i);
        return r;
    endfunction

    function automatic map_t identity_map();
        map_t m;
        for (int i = 0; i < LREGS; i++) m[i] = preg_t'(i);
        return m;
    endfunction

    function automatic pvec_t spare_regs();
        pvec_t v = '0;
        for (int i = LREGS; i < PREGS; i++) v[i] = 1'b1;
        return v;
    endfunction
endpackage

// File: rtl/rn_freelist.sv
module rn_freelist
    import rn_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  alloc_en,
    input  logic  grad_en,
    input  preg_t grad_tag,
    input  logic  restore_en,
    input  pvec_t restore_mask,
    output preg_t pick,
    output logic  empty
);
    pvec_t free_q, free_d;

    assign empty = ~|free_q;
    assign pick  = first_free(free_q);

    always_comb begin
        free_d = free_q;
        if (grad_en)    free_d[grad_tag] = 1'b1;
        if (restore_en) free_d = free_d | restore_mask;
        if (alloc_en)   free_d[pick] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) free_q <= spare_regs();
        else     free_q <= free_d;
    end
endmodule

// File: rtl/rn_busy.sv
module rn_busy
    import rn_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  set_en,
    input  preg_t set_tag,
    input  logic  clr_en,
    input  preg_t clr_tag,
    input  preg_t rd_a,
    input  preg_t rd_b,
    output logic  bsy_a,
    output logic  bsy_b
);
    pvec_t busy_q;

    assign bsy_a = busy_q[rd_a] && !(clr_en && clr_tag == rd_a);
    assign bsy_b = busy_q[rd_b] && !(clr_en && clr_tag == rd_b);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= '0;
        end else begin
            if (clr_en) busy_q[clr_tag] <= 1'b0;
            if (set_en) busy_q[set_tag] <= 1'b1;
        end
    end
endmodule

// File: rtl/rn_ckpt.sv
module rn_ckpt
    import rn_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   push_en,
    input  map_t   push_map,
    input  addr_t  push_alt,
    input  logic   alloc_en,
    input  preg_t  alloc_tag,
    input  logic   resolve_en,
    input  logic   mis_en,
    input  ckidx_t mis_idx,
    output logic   full,
    output ckidx_t tail,
    output map_t   rd_map,
    output pvec_t  rd_since,
    output addr_t  rd_alt
);
    ckpt_t  ent_q [NCKPT];
    ckidx_t head_q;
    ckcnt_t cnt_q;
    logic   [NCKPT-1:0] live;

    assign full     = (cnt_q == ckcnt_t'(NCKPT));
    assign tail     = head_q + cnt_q[CW-1:0];
    assign rd_map   = ent_q[mis_idx].map;
    assign rd_since = ent_q[mis_idx].since;
    assign rd_alt   = ent_q[mis_idx].alt;

    for (genvar g = 0; g < NCKPT; g++) begin : g_slot
        ckidx_t age;
        assign age     = ckidx_t'(g) - head_q;
        assign live[g] = {1'b0, age} < cnt_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                ent_q[g] <= '0;
            end else if (!mis_en) begin
                if (push_en && tail == ckidx_t'(g))
                    ent_q[g] <= '{map: push_map, since: '0, alt: push_alt};
                else if (alloc_en && live[g])
                    ent_q[g].since[alloc_tag] <= 1'b1;
            end
        end
    end

    logic res_go;
    assign res_go = resolve_en && (cnt_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q <= '0;
            cnt_q  <= '0;
        end else if (mis_en) begin
            cnt_q <= {1'b0, ckidx_t'(mis_idx - head_q)};
        end else begin
            cnt_q  <= cnt_q + ckcnt_t'(push_en) - ckcnt_t'(res_go);
            head_q <= head_q + ckidx_t'(res_go);
        end
    end
endmodule

// File: rtl/rename_ckpt.sv
module rename_ckpt
    import rn_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [LW-1:0]        src_a,
    input  logic [LW-1:0]        src_b,
    input  logic [LW-1:0]        dst,
    input  logic                 has_dst,
    input  logic                 is_branch,
    input  logic [ADDR_W-1:0]    br_alt,
    input  logic                 mispredict,
    input  logic [CW-1:0]        mis_idx,
    input  logic                 br_ok,
    input  logic                 wb_valid,
    input  logic [PW-1:0]        wb_tag,
    input  logic                 grad_valid,
    input  logic [PW-1:0]        grad_tag,
    output logic                 ren_ok,
    output logic                 stall,
    output logic [PW-1:0]        phys_a,
    output logic [PW-1:0]        phys_b,
    output logic [PW-1:0]        phys_d,
    output logic [PW-1:0]        phys_old,
    output logic                 busy_a,
    output logic                 busy_b,
    output logic [CW-1:0]        ckpt_idx,
    output logic [ADDR_W-1:0]    redirect_addr
);
    map_t   map_q, map_next, ck_rd_map;
    pvec_t  ck_rd_since;
    preg_t  fl_pick;
    logic   fl_empty, ck_full, need_hold, alloc;

    assign need_hold = (has_dst && fl_empty) || (is_branch && ck_full);
    assign stall     = in_valid && !mispredict && need_hold;
    assign ren_ok    = in_valid && !mispredict && !need_hold;
    assign alloc     = ren_ok && has_dst;

    assign phys_a   = map_q[src_a];
    assign phys_b   = map_q[src_b];
    assign phys_old = map_q[dst];
    assign phys_d   = fl_pick;

    always_comb begin
        map_next = map_q;
        if (has_dst) map_next[dst] = fl_pick;
    end

    always_ff @(posedge clk) begin
        if (rst)             map_q <= identity_map();
        else if (mispredict) map_q <= ck_rd_map;
        else if (alloc)      map_q[dst] <= fl_pick;
    end

    rn_freelist u_free (
        .clk(clk), .rst(rst),
        .alloc_en(alloc),
        .grad_en(grad_valid), .grad_tag(grad_tag),
        .restore_en(mispredict), .restore_mask(ck_rd_since),
        .pick(fl_pick), .empty(fl_empty)
    );

    rn_busy u_busy (
        .clk(clk), .rst(rst),
        .set_en(alloc), .set_tag(fl_pick),
        .clr_en(wb_valid), .clr_tag(wb_tag),
        .rd_a(phys_a), .rd_b(phys_b),
        .bsy_a(busy_a), .bsy_b(busy_b)
    );

    rn_ckpt u_ckpt (
        .clk(clk), .rst(rst),
        .push_en(ren_ok && is_branch), .push_map(map_next), .push_alt(br_alt),
        .alloc_en(alloc), .alloc_tag(fl_pick),
        .resolve_en(br_ok),
        .mis_en(mispredict), .mis_idx(mis_idx),
        .full(ck_full), .tail(ckpt_idx),
        .rd_map(ck_rd_map), .rd_since(ck_rd_since), .rd_alt(redirect_addr)
    );
endmodule

// File: rtl/rename_ckpt_chk.sv
module rename_ckpt_chk
    import rn_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic        has_dst,
    input logic        is_branch,
    input logic        mispredict,
    input logic        wb_valid,
    input logic [PW-1:0] wb_tag,
    input logic        ren_ok,
    input logic        stall,
    input logic [PW-1:0] phys_a,
    input logic [PW-1:0] phys_d,
    input logic [PW-1:0] phys_old,
    input logic        busy_a,
    input logic        fl_empty,
    input logic        ck_full,
    input map_t        map_q,
    input map_t        ck_rd_map
);
    // R7
    empty_stall_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid && has_dst && fl_empty && !mispredict |-> stall && !ren_ok);

    // R8
    full_stall_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid && is_branch && ck_full |-> !ren_ok);

    // R10
    mis_no_rename_chk: assert property (@(posedge clk) disable iff (rst)
        mispredict |-> !ren_ok);

    // R3
    fresh_tag_chk: assert property (@(posedge clk) disable iff (rst)
        ren_ok && has_dst |-> phys_d != phys_old);

    // R9
    restore_chk: assert property (@(posedge clk) disable iff (rst)
        mispredict |=> map_q == $past(ck_rd_map));

    // R5
    wb_bypass_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid && wb_valid && wb_tag == phys_a |-> !busy_a);
endmodule

bind rename_ckpt rename_ckpt_chk u_chk (.*);

// File: tb/sim_rename_ckpt.sv
module sim_rename_ckpt;
    logic clk = 0, rst = 1;
    logic in_valid = 0, has_dst = 0, is_branch = 0, mispredict = 0, br_ok = 0;
    logic wb_valid = 0, grad_valid = 0;
    logic [4:0] src_a = 0, src_b = 0, dst = 0;
    logic [31:0] br_alt = 0;
    logic [1:0] mis_idx = 0;
    logic [5:0] wb_tag = 0, grad_tag = 0;
    logic ren_ok, stall, busy_a, busy_b;
    logic [5:0] phys_a, phys_b, phys_d, phys_old;
    logic [1:0] ckpt_idx;
    logic [31:0] redirect_addr;

    always #5 clk = ~clk;

    rename_ckpt u0 (.*);

    typedef struct {
        bit ok, st, hd, br, mis;
        int pa, pb, pd, po, ck;
        bit ba, bb;
        logic [31:0] rd;
        string tag;
    } exp_t;
    exp_t q[$];

    int checks = 0, errors = 0;
    int mmap[32];
    bit mfree[64], mbusy[64];
    int cmap[4][32];
    bit cmask[4][64];
    logic [31:0] caddr[4];
    int head = 0, cnt = 0;

    task automatic chk(bit good, string tag, string what, int act, int exp);
        checks++;
        if (!good) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int low_free();
        for (int p = 0; p < 64; p++) if (mfree[p]) return p;
        return 0;
    endfunction

    function automatic bit any_free();
        for (int p = 0; p < 64; p++) if (mfree[p]) return 1;
        return 0;
    endfunction

    task automatic step(bit v, int sa, int sb, int d, bit hd, bit br,
                        logic [31:0] alt, bit mis, int midx, bit rok,
                        bit wv, int wt, bit gv, int gt, string tag);
        exp_t e;
        int ocnt;
        @(negedge clk); #1;
        in_valid = v; src_a = 5'(sa); src_b = 5'(sb); dst = 5'(d);
        has_dst = hd; is_branch = br; br_alt = alt; mispredict = mis;
        mis_idx = 2'(midx); br_ok = rok; wb_valid = wv; wb_tag = 6'(wt);
        grad_valid = gv; grad_tag = 6'(gt);
        e.tag = tag; e.hd = hd; e.br = br; e.mis = mis;
        e.st = v && !mis && ((hd && !any_free()) || (br && cnt == 4));
        e.ok = v && !mis && !e.st;
        e.pa = mmap[sa]; e.pb = mmap[sb]; e.po = mmap[d]; e.pd = low_free();
        e.ba = mbusy[e.pa] && !(wv && wt == e.pa);
        e.bb = mbusy[e.pb] && !(wv && wt == e.pb);
        e.ck = (head + cnt) % 4;
        e.rd = caddr[midx];
        q.push_back(e);
        ocnt = cnt;
        if (mis) begin
            mmap = cmap[midx];
            for (int p = 0; p < 64; p++) if (cmask[midx][p]) mfree[p] = 1;
            cnt = (midx - head + 4) % 4;
        end else begin
            if (e.ok && hd) begin
                for (int i = 0; i < ocnt; i++) cmask[(head + i) % 4][e.pd] = 1;
                mfree[e.pd] = 0; mbusy[e.pd] = 1; mmap[d] = e.pd;
            end
            if (e.ok && br) begin
                cmap[e.ck] = mmap;
                for (int p = 0; p < 64; p++) cmask[e.ck][p] = 0;
                caddr[e.ck] = alt; cnt++;
            end
            if (rok && ocnt > 0) begin head = (head + 1) % 4; cnt--; end
        end
        if (wv) mbusy[wt] = 0;
        if (gv) mfree[gt] = 1;
    endtask

    task automatic ren(int sa, int sb, int d, bit hd, string tag);
        step(1, sa, sb, d, hd, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic brn(logic [31:0] alt, bit rok, string tag);
        step(1, 0, 0, 0, 0, 1, alt, 0, 0, rok, 0, 0, 0, 0, tag);
    endtask

    task automatic idle();
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "idle");
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            @(negedge clk); #3;
            if (q.size() > 0) begin
                e = q.pop_front();
                chk(ren_ok == e.ok, e.tag, "ren_ok", ren_ok, e.ok);
                chk(stall == e.st, e.tag, "stall", stall, e.st);
                if (e.ok) begin
                    chk(phys_a == e.pa, e.tag, "phys_a", phys_a, e.pa);
                    chk(phys_b == e.pb, e.tag, "phys_b", phys_b, e.pb);
                    chk(busy_a == e.ba, e.tag, "busy_a", busy_a, e.ba);
                    chk(busy_b == e.bb, e.tag, "busy_b", busy_b, e.bb);
                    if (e.hd) begin
                        chk(phys_d == e.pd, e.tag, "phys_d", phys_d, e.pd);
                        chk(phys_old == e.po, e.tag, "phys_old", phys_old, e.po);
                    end
                    if (e.br) chk(ckpt_idx == e.ck, e.tag, "ckpt_idx", ckpt_idx, e.ck);
                end
                if (e.mis)
                    chk(redirect_addr == e.rd, e.tag, "redirect", int'(redirect_addr), int'(e.rd));
            end
        end
    end

    initial begin : watchdog
        #2000000;
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : driver
        for (int i = 0; i < 32; i++) mmap[i] = i;
        for (int p = 0; p < 64; p++) begin mfree[p] = (p >= 32); mbusy[p] = 0; end
        for (int k = 0; k < 4; k++) caddr[k] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        // R1: identity map and clear busy after reset
        ren(5, 31, 0, 0, "R1");
        // R3: lowest free tag 32, old tag 1
        ren(2, 3, 1, 1, "R3");
        // R4: reader of fresh tag sees busy
        ren(1, 1, 4, 1, "R4");
        // R2: source and old tag read before own update
        ren(5, 5, 5, 1, "R2");
        // R5: writeback of tag 32 bypasses to the reader
        step(1, 1, 4, 6, 1, 0, 0, 0, 0, 0, 1, 32, 0, 0, "R5");
        ren(1, 4, 0, 0, "R5");
        // R6: graduated tag 1 becomes the lowest free
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, "R6");
        ren(7, 7, 7, 1, "R6");
        // R8 and R9: checkpoints, then mispredict to slot 0
        brn(32'hA000_0100, 0, "R8");
        ren(1, 1, 1, 1, "R8");
        brn(32'hB000_0200, 0, "R8");
        ren(2, 2, 2, 1, "R8");
        step(1, 0, 0, 3, 1, 0, 0, 1, 0, 0, 0, 0, 0, 0, "R10");
        ren(1, 2, 8, 1, "R9");
        // R8: fill four slots, fifth stalls
        brn(32'h0000_1000, 0, "R8");
        brn(32'h0000_1004, 0, "R8");
        brn(32'h0000_1008, 0, "R8");
        brn(32'h0000_100C, 0, "R8");
        brn(32'h0000_1010, 0, "R8");
        // R11: resolve uses start-of-cycle count, then frees oldest
        brn(32'h0000_1014, 1, "R11");
        idle();
        brn(32'h0000_1018, 0, "R11");
        ren(9, 9, 9, 1, "R11");
        // R10: mispredict to second-oldest drops it and the younger ones
        step(1, 0, 0, 0, 0, 1, 1, 1, (head + 1) % 4, 1, 0, 0, 0, 0, "R10");
        ren(9, 9, 10, 0, "R9");
        brn(32'h0000_2000, 0, "R10");
        brn(32'h0000_2004, 0, "R10");
        brn(32'h0000_2008, 0, "R10");
        brn(32'h0000_200C, 0, "R10");
        // R7: drain the free list until stall
        for (int i = 0; i < 40; i++) ren(i % 32, (i + 3) % 32, (i * 7) % 32, 1, "R7");
        ren(3, 4, 11, 1, "R7");
        begin
            int gt = 0;
            for (int p = 63; p >= 0; p--) if (!mfree[p]) gt = p;
            step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, gt, "R6");
        end
        ren(11, 12, 11, 1, "R7");
        ren(11, 12, 13, 1, "R7");
        idle();
        idle();
        #20;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule